// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Start-Up Delay

This block produces the internal reset level of a small microcontroller core. Power-on, brown-out and watchdog events, a wake-up request, and a low level on the external master clear pin all set a reset latch. The latch is released only by a start-up delay counter. That counter runs on the free-running RC clock, and it runs only while master clear, after synchronization, is high and no event is pending. Supply-threshold detection is done elsewhere, so each event arrives here as a one-cycle digital pulse on the RC clock domain.

The delay has two lengths. The power-on path uses the full counter range of 2^CNT_W cycles. Brown-out, watchdog and wake-up resets use a shorter delay of SHORT_LEN cycles. A master clear pulse on its own keeps whichever length the most recent event selected. The block also presents the program-counter preload, which is the top address of program memory, and a one-cycle flag that marks expiry of the delay.

Top module: `core_reset_seq`

## Requirements
- R1: One cycle after a power-on pulse, core_rst reads 1 and the full delay (2^CNT_W counts) is selected. With mclr_n held high, core_rst reads 0 from 2^CNT_W+4 cycles after the pulse was applied.
- R2: A brown-out, watchdog or wake-up pulse drives core_rst to 1 on the next clock edge.
- R3: After a brown-out, watchdog or wake-up pulse, with mclr_n high, core_rst reads 0 from SHORT_LEN+2 cycles after the pulse.
- R4: mclr_n passes through two RC-clock flops before it can enable counting. After mclr_n rises, core_rst reads 0 from L+3 cycles later, where L is the delay length currently selected.
- R5: While the synchronized master clear is low, core_rst stays at 1 and dly_done stays at 0, however long the low level lasts.
- R6: Any event pulse that arrives while the delay is counting clears the count. The delay then restarts in full from that pulse, using the length that the pulse selects.
- R7: dly_done is high for exactly one cycle, the last cycle in which core_rst is 1.
- R8: pc_init always equals the all-ones value of PC_W bits, which is 0x7FF for PC_W = 11.
- R9: core_rst falls only on the edge that follows a dly_done pulse.
- R10: A master clear pulse without any other event leaves the selected delay length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running RC-derived clock |
| por_evt | input | 1 | Power-on pulse; also clears the synchronizer |
| bor_evt | input | 1 | Brown-out event pulse |
| wdt_evt | input | 1 | Watchdog timeout pulse |
| wake_evt | input | 1 | Wake-up request pulse |
| mclr_n | input | 1 | Asynchronous active-low master clear pin |
| core_rst | output | 1 | Registered internal reset level, active high |
| pc_init | output | PC_W | Program-counter preload, top of program memory |
| dly_done | output | 1 | One-cycle pulse at the delay terminal count |

## Verification
The bench builds the block with CNT_W = 6, SHORT_LEN = 5 and PC_W = 11. This gives a 64-cycle power-on delay and a 5-cycle short delay. Both lengths, restarts in the middle of a count and master clear pulses can then be repeated dozens of times in a short run. PC_W = 11 makes the expected preload the 0x7FF value of a 2048-word memory. Interruption points are drawn at random, so restarts land both just after a count begins and just before it ends.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic {DLY_SHORT = 1'b0, DLY_LONG = 1'b1} dly_mode_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (clr) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_delay.sv
module rsq_delay
  import rsq_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int SHORT_LEN = 16
) (
  input  logic clk,
  input  logic por_evt,
  input  logic alt_evt,
  input  logic run,
  output logic done
);
  localparam logic [CNT_W-1:0] LONG_TERM  = '1;
  localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_LEN - 1);

  dly_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             hit;

  // power-on wins over the other sources; master clear alone keeps the mode
  always_ff @(posedge clk) begin
    if (por_evt)      mode_q <= DLY_LONG;
    else if (alt_evt) mode_q <= DLY_SHORT;
  end

  assign term = (mode_q == DLY_LONG) ? LONG_TERM : SHORT_TERM;
  assign hit  = run && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!run || hit) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    done <= hit;
  end
endmodule

// File: rtl/rsq_latch.sv
module rsq_latch (
  input  logic clk,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set dominates release
  always_ff @(posedge clk) begin
    if (set)      q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/core_reset_seq.sv
module core_reset_seq #(
  parameter int CNT_W     = 10,
  parameter int SHORT_LEN = 16,
  parameter int PC_W      = 11
) (
  input  logic            clk,
  input  logic            por_evt,
  input  logic            bor_evt,
  input  logic            wdt_evt,
  input  logic            wake_evt,
  input  logic            mclr_n,
  output logic            core_rst,
  output logic [PC_W-1:0] pc_init,
  output logic            dly_done
);
  localparam logic [PC_W-1:0] TOP_ADDR = '1;

  logic mclr_s;
  logic alt_evt;
  logic any_evt;
  logic run;

  assign alt_evt = bor_evt | wdt_evt | wake_evt;
  assign any_evt = por_evt | alt_evt;
  assign run     = core_rst & mclr_s & ~any_evt;

  rsq_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .clr (por_evt),
    .d   (mclr_n),
    .q   (mclr_s)
  );

  rsq_delay #(.CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN)) u_delay (
    .clk     (clk),
    .por_evt (por_evt),
    .alt_evt (alt_evt),
    .run     (run),
    .done    (dly_done)
  );

  rsq_latch u_latch (
    .clk (clk),
    .set (any_evt | ~mclr_s),
    .clr (dly_done),
    .q   (core_rst)
  );

  always_ff @(posedge clk) begin
    pc_init <= TOP_ADDR;
  end
endmodule

// File: rtl/core_reset_chk.sv
module core_reset_chk (
  input logic clk,
  input logic por_evt,
  input logic bor_evt,
  input logic wdt_evt,
  input logic wake_evt,
  input logic mclr_s,
  input logic core_rst,
  input logic dly_done
);
  a_r2_source_sets: assert property (@(posedge clk) disable iff (por_evt)
    (bor_evt | wdt_evt | wake_evt) |=> core_rst);

  a_r5_mclr_holds: assert property (@(posedge clk) disable iff (por_evt)
    !mclr_s |=> (core_rst && !dly_done));

  a_r7_done_single: assert property (@(posedge clk) disable iff (por_evt)
    dly_done |=> !dly_done);

  a_r7_done_in_reset: assert property (@(posedge clk) disable iff (por_evt)
    dly_done |-> core_rst);

  a_r9_release_cause: assert property (@(posedge clk) disable iff (por_evt)
    $fell(core_rst) |-> $past(dly_done));

  a_r4_done_needs_mclr: assert property (@(posedge clk) disable iff (por_evt)
    dly_done |-> $past(mclr_s));
endmodule

bind core_reset_seq core_reset_chk u_chk (
  .clk      (clk),
  .por_evt  (por_evt),
  .bor_evt  (bor_evt),
  .wdt_evt  (wdt_evt),
  .wake_evt (wake_evt),
  .mclr_s   (mclr_s),
  .core_rst (core_rst),
  .dly_done (dly_done)
);

// File: tb/core_reset_seq_test.sv
module core_reset_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W     = 6;
  localparam int SHORT_LEN = 5;
  localparam int PC_W      = 11;
  localparam int LONG_LEN  = 1 << CNT_W;

  logic            clk = 1'b0;
  logic            por_evt = 1'b1;
  logic            bor_evt = 1'b0;
  logic            wdt_evt = 1'b0;
  logic            wake_evt = 1'b0;
  logic            mclr_n = 1'b1;
  logic            core_rst;
  logic [PC_W-1:0] pc_init;
  logic            dly_done;

  int checks = 0;
  int fails  = 0;
  bit long_mode = 1'b1;
  bit finished  = 1'b0;

  always #2.5 clk = ~clk;

  core_reset_seq #(.CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN), .PC_W(PC_W)) uut (
    .clk(clk), .por_evt(por_evt), .bor_evt(bor_evt), .wdt_evt(wdt_evt),
    .wake_evt(wake_evt), .mclr_n(mclr_n), .core_rst(core_rst),
    .pc_init(pc_init), .dly_done(dly_done)
  );

  function automatic int cur_len();
    return long_mode ? LONG_LEN : SHORT_LEN;
  endfunction

  function automatic int exp_event(int src);
    return (src == 0) ? LONG_LEN + 4 : SHORT_LEN + 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // src: 0 power-on, 1 brown-out, 2 watchdog, 3 wake-up
  task automatic pulse_src(int src);
    @(negedge clk);
    case (src)
      0: por_evt = 1'b1;
      1: bor_evt = 1'b1;
      2: wdt_evt = 1'b1;
      default: wake_evt = 1'b1;
    endcase
    @(negedge clk);
    por_evt = 1'b0; bor_evt = 1'b0; wdt_evt = 1'b0; wake_evt = 1'b0;
    long_mode = (src == 0) ? 1'b1 : 1'b0;
  endtask

  // current sample is n=1; measure cycles to release and the done pulse
  task automatic measure(int exp, string req);
    int n = 1;
    int done_n = -1;
    int done_cnt = 0;
    check(core_rst == 1'b1, "R2/R5 reset set", core_rst, 1);
    while (core_rst == 1'b1 && n < 4 * LONG_LEN) begin
      if (dly_done) begin done_cnt++; done_n = n; end
      @(negedge clk);
      n++;
    end
    check(n == exp, req, n, exp);
    check(done_cnt == 1 && done_n == exp - 1, "R7 done pulse", done_n, exp - 1);
    @(negedge clk);
    check(dly_done == 1'b0 && core_rst == 1'b0, "R9 stays released", core_rst, 0);
  endtask

  task automatic mclr_trial(int low_cycles);
    int exp;
    @(negedge clk);
    mclr_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    mclr_n = 1'b1;
    @(negedge clk);
    exp = cur_len() + 3;
    measure(exp, "R4/R10 mclr release");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2468));
    repeat (2) @(negedge clk);
    check(core_rst == 1'b1, "R1 reset during power-on", core_rst, 1);
    check(pc_init == PC_W'((1 << PC_W) - 1), "R8 pc preload", int'(pc_init), (1 << PC_W) - 1);
    por_evt = 1'b0;
    @(negedge clk);
    // power-on released in the previous sample; measure from here is n=1
    measure(LONG_LEN + 3, "R1 power-on release");

    // directed: each short source
    for (int s = 1; s < 4; s++) begin
      pulse_src(s);
      measure(exp_event(s), "R3 short delay");
    end
    pulse_src(0);
    measure(exp_event(0), "R1 long delay");

    // directed R5: master clear held low well past the long delay
    @(negedge clk);
    mclr_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < LONG_LEN + 10; i++) begin
      if (core_rst !== 1'b1 || dly_done !== 1'b0) begin
        check(1'b0, "R5 mclr low holds", core_rst, 1);
        break;
      end
      @(negedge clk);
    end
    check(core_rst == 1'b1, "R5 mclr low holds", core_rst, 1);
    mclr_n = 1'b1;
    @(negedge clk);
    measure(cur_len() + 3, "R4 release after mclr");

    // R10: short mode survives a master clear pulse
    pulse_src(2);
    measure(exp_event(2), "R3 short delay");
    mclr_trial(3);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind = int'($urandom_range(0, 2));
      if (kind == 0) begin
        int s = int'($urandom_range(0, 3));
        pulse_src(s);
        measure(exp_event(s), "R1/R3 event release");
      end else if (kind == 1) begin
        mclr_trial(int'($urandom_range(3, 6)));
      end else begin
        int s1 = int'($urandom_range(0, 3));
        int s2 = int'($urandom_range(0, 3));
        int k;
        pulse_src(s1);
        k = int'($urandom_range(1, cur_len() - 1));
        repeat (k) @(negedge clk);
        check(core_rst == 1'b1, "R6 still counting", core_rst, 1);
        pulse_src(s2);
        measure(exp_event(s2), "R6 restart full delay");
      end
    end
    check(pc_init == PC_W'((1 << PC_W) - 1), "R8 pc preload", int'(pc_init), (1 << PC_W) - 1);
    finish_run();
  end
endmodule